// File: doc/BRIEF.md
# Parity/Overflow Status Flag Unit

This block produces the single status bit that a CPU datapath shares between two meanings: an even-parity indicator and a two's-complement overflow indicator. Which meaning the bit takes is chosen per operation by an instruction-class code from the upstream decoder. Arithmetic operations store the XOR of the carry into the most significant bit and the carry out of it. Logical, shift/rotate and check operations store 1 when the result holds an even number of ones and 0 when it holds an odd number.

The flag is held in a register that a branch unit can test. The register updates only on a clock edge where the write enable is high and the class is one that affects the flag. Every other class keeps the stored bit. Operand size is 8 or 16 bits. With 8-bit size only the low byte of the result is used. Shifts always take parity over the low byte, even when the shift is 16 bits wide.

Top module: `pv_flag_unit`

## Requirements
- R1: While `rst_n` is low the flag is 0, and it stays 0 until the first qualifying write.
- R2: With `wr_en` high and class code 0 (arithmetic), the flag after the edge equals `msb_cin` XOR `msb_cout`, at either size.
- R3: With `wr_en` high, class 1 (logical) or 3 (check) and `wide` low, the flag after the edge is 1 when `result[7:0]` has an even count of ones and 0 when the count is odd.
- R4: With `wr_en` high, class 1 or 3 and `wide` high, the flag after the edge is the even-parity indication of all of `result[15:0]`.
- R5: With `wr_en` high and class 2 (shift/rotate), the flag after the edge is the even-parity indication of `result[7:0]` only, whether `wide` is low or high.
- R6: Class codes 4 to 7 (operations that do not touch the flag) leave the flag unchanged even when `wr_en` is high.
- R7: With `wr_en` low the flag is unchanged, whatever the other inputs are.
- R8: 0x78 + 0x69 (carry into bit 7 = 1, carry out = 0) sets the flag. 0xFB + 0xF0 (carry into bit 7 = 1, carry out = 1) clears it.
- R9: For 8-bit logical and check operations, `result[15:8]` has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the flag |
| wr_en | input | 1 | Flag write enable for this cycle |
| op_class | input | 3 | Class code: 0 arithmetic, 1 logical, 2 shift/rotate, 3 check, 4-7 no effect |
| wide | input | 1 | Operand size: 0 for 8-bit, 1 for 16-bit |
| result | input | 16 | ALU result of the current operation |
| msb_cin | input | 1 | Carry into the operand's most significant bit |
| msb_cout | input | 1 | Carry out of the operand's most significant bit |
| pv_flag | output | 1 | Registered parity/overflow flag |

## Verification
The stored bit is the block's only internal state. A wrong value appears at `pv_flag` one edge after the write that produced it. A wrong update from a no-effect class or a disabled write shows only as a changed flag on the next edge, so the bench reads the flag after every such vector. A wrong parity span shows only for results whose high byte has odd parity, so the random results cover both cases. Wrong overflow wiring shows when the two MSB carries differ.

// File: rtl/pv_flag_pkg.sv
package pv_flag_pkg;
    parameter int DATA_W   = 16;
    parameter int NARROW_W = 8;

    typedef enum logic [2:0] {
        CLS_ARITH = 3'd0,
        CLS_LOGIC = 3'd1,
        CLS_SHIFT = 3'd2,
        CLS_CHECK = 3'd3
    } op_class_e;
endpackage

// File: rtl/pv_parity_unit.sv
module pv_parity_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_in,
    output logic         even_out
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_xor
            assign chain[i+1] = chain[i] ^ bits_in[i];
        end
    endgenerate

    assign even_out = ~chain[W];
endmodule

// File: rtl/pv_next_sel.sv
module pv_next_sel
    import pv_flag_pkg::*;
(
    input  logic [2:0] op_class,
    input  logic       wide,
    input  logic       even_lo,
    input  logic       odd_hi,
    input  logic       ovf,
    output logic       next_pv,
    output logic       affects
);
    always_comb begin
        next_pv = 1'b0;
        affects = 1'b0;
        case (op_class)
            CLS_ARITH: begin
                next_pv = ovf;
                affects = 1'b1;
            end
            CLS_LOGIC, CLS_CHECK: begin
                next_pv = wide ? (even_lo ^ odd_hi) : even_lo;
                affects = 1'b1;
            end
            CLS_SHIFT: begin
                next_pv = even_lo;
                affects = 1'b1;
            end
            default: begin
                next_pv = 1'b0;
                affects = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pv_flag_unit.sv
module pv_flag_unit
    import pv_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        op_class,
    input  logic              wide,
    input  logic [DATA_W-1:0] result,
    input  logic              msb_cin,
    input  logic              msb_cout,
    output logic              pv_flag
);
    localparam int HI_W = DATA_W - NARROW_W;

    logic even_lo;
    logic even_hi;
    logic next_pv;
    logic affects;
    logic pv_q;

    pv_parity_unit #(.W(NARROW_W)) u_par_lo (
        .bits_in  (result[NARROW_W-1:0]),
        .even_out (even_lo)
    );

    pv_parity_unit #(.W(HI_W)) u_par_hi (
        .bits_in  (result[DATA_W-1:NARROW_W]),
        .even_out (even_hi)
    );

    pv_next_sel u_sel (
        .op_class (op_class),
        .wide     (wide),
        .even_lo  (even_lo),
        .odd_hi   (~even_hi),
        .ovf      (msb_cin ^ msb_cout),
        .next_pv  (next_pv),
        .affects  (affects)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pv_q <= 1'b0;
        else if (wr_en && affects)
            pv_q <= next_pv;
    end

    assign pv_flag = pv_q;
endmodule

// File: rtl/pv_flag_checker.sv
module pv_flag_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  op_class,
    input logic        wide,
    input logic [15:0] result,
    input logic        msb_cin,
    input logic        msb_cout,
    input logic        pv_flag
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !pv_flag);

    a_r2_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_class == 3'd0) |=> pv_flag == ($past(msb_cin) ^ $past(msb_cout)));

    a_r3_narrow_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide && (op_class == 3'd1 || op_class == 3'd3))
        |=> pv_flag == ~(^$past(result[7:0])));

    a_r4_wide_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wide && (op_class == 3'd1 || op_class == 3'd3))
        |=> pv_flag == ~(^$past(result)));

    a_r5_shift_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_class == 3'd2) |=> pv_flag == ~(^$past(result[7:0])));

    a_r6_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || op_class[2]) |=> $stable(pv_flag));
endmodule

bind pv_flag_unit pv_flag_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .op_class (op_class),
    .wide     (wide),
    .result   (result),
    .msb_cin  (msb_cin),
    .msb_cout (msb_cout),
    .pv_flag  (pv_flag)
);

// File: tb/pv_flag_unit_tb.sv
`timescale 1ns/1ps
module pv_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  op_class = 3'd7;
    logic        wide = 1'b0;
    logic [15:0] result = '0;
    logic        msb_cin = 1'b0;
    logic        msb_cout = 1'b0;
    logic        pv_flag;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic model = 1'b0;

    always #5 clk = ~clk;

    pv_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_class(op_class),
        .wide(wide), .result(result), .msb_cin(msb_cin),
        .msb_cout(msb_cout), .pv_flag(pv_flag)
    );

    function automatic logic even_ones(input logic [15:0] v, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += v[i];
        return (c % 2) == 0;
    endfunction

    function automatic logic expect_pv(input logic cur, input logic we, input logic [2:0] cls,
                                       input logic w, input logic [15:0] r,
                                       input logic ci, input logic co);
        if (!we) return cur;
        case (cls)
            3'd0: return ci ^ co;
            3'd1, 3'd3: return even_ones(r, w ? 16 : 8);
            3'd2: return even_ones(r, 8);
            default: return cur;
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        n_vec++;
        if (pv_flag !== exp) begin
            n_bad++;
            $display("FAIL %s: pv_flag=%b expected=%b", req, pv_flag, exp);
        end
    endtask

    task automatic apply(input string req, input logic we, input logic [2:0] cls,
                         input logic w, input logic [15:0] r, input logic ci, input logic co);
        wr_en = we; op_class = cls; wide = w; result = r; msb_cin = ci; msb_cout = co;
        @(posedge clk);
        model = expect_pv(model, we, cls, w, r, ci, co);
        @(negedge clk);
        check(req, model);
    endtask

    // Add two operands, derive MSB carries, and the expected overflow from signed range
    task automatic add_op(input string req, input logic w, input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        logic ci, co, ovf;
        int sa, sb, st;
        if (w) begin
            s  = {1'b0, a} + {1'b0, b};
            ci = (({1'b0, a[14:0]} + {1'b0, b[14:0]}) >> 15) != 0;
            co = s[16];
            sa = $signed(a); sb = $signed(b);
            st = sa + sb;
            ovf = (st > 32767) || (st < -32768);
        end else begin
            s  = {9'b0, a[7:0]} + {9'b0, b[7:0]};
            ci = (({1'b0, a[6:0]} + {1'b0, b[6:0]}) >> 7) != 0;
            co = s[8];
            sa = $signed(a[7:0]); sb = $signed(b[7:0]);
            st = sa + sb;
            ovf = (st > 127) || (st < -128);
        end
        apply(req, 1'b1, 3'd0, w, s[15:0], ci, co);
        n_vec++;
        if (pv_flag !== ovf) begin
            n_bad++;
            $display("FAIL %s: pv_flag=%b expected overflow=%b", req, pv_flag, ovf);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: pv_flag=%b expected=completion", pv_flag);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0);

        // R8 directed examples
        add_op("R8 78+69", 1'b0, 16'h0078, 16'h0069);
        check("R8 flag set", 1'b1);
        add_op("R8 FB+F0", 1'b0, 16'h00FB, 16'h00F0);
        check("R8 flag clear", 1'b0);
        add_op("R2 16-bit 7FFF+1", 1'b1, 16'h7FFF, 16'h0001);
        add_op("R2 16-bit 8000+FFFF", 1'b1, 16'h8000, 16'hFFFF);

        // R3 / R9: high byte ignored for 8-bit logic
        apply("R3 logic even", 1'b1, 3'd1, 1'b0, 16'h0003, 1'b0, 1'b0);
        apply("R9 high byte odd ignored", 1'b1, 3'd1, 1'b0, 16'h0103, 1'b0, 1'b0);
        apply("R3 check odd", 1'b1, 3'd3, 1'b0, 16'hFF07, 1'b0, 1'b0);
        // R4: full 16 bits
        apply("R4 wide odd via high byte", 1'b1, 3'd1, 1'b1, 16'h0103, 1'b0, 1'b0);
        apply("R4 wide even", 1'b1, 3'd3, 1'b1, 16'h1103, 1'b0, 1'b0);
        // R5: 16-bit shift uses low byte only
        apply("R5 wide shift", 1'b1, 3'd2, 1'b1, 16'h0100, 1'b0, 1'b0);
        apply("R5 narrow shift odd", 1'b1, 3'd2, 1'b0, 16'h0001, 1'b0, 1'b0);
        // R6 / R7 hold
        apply("R6 class 5 holds", 1'b1, 3'd5, 1'b0, 16'h0000, 1'b1, 1'b0);
        apply("R7 disabled arith holds", 1'b0, 3'd0, 1'b0, 16'h0000, 1'b1, 1'b0);
        apply("R2 set via arith", 1'b1, 3'd0, 1'b0, 16'h0000, 1'b0, 1'b1);
        apply("R6 class 7 holds set", 1'b1, 3'd7, 1'b1, 16'h0001, 1'b1, 1'b1);
        apply("R7 disabled logic holds set", 1'b0, 3'd1, 1'b0, 16'h0001, 1'b0, 1'b0);

        for (int k = 0; k < 600; k++) begin
            logic [2:0] c;
            logic w;
            c = 3'($urandom_range(0, 7));
            w = 1'($urandom);
            if (c == 3'd0 && ($urandom % 2) == 0)
                add_op("R2 random add", w, 16'($urandom), 16'($urandom));
            else
                apply(c == 3'd0 ? "R2 random" : c == 3'd2 ? "R5 random" :
                      c[2] ? "R6 random" : (w ? "R4 random" : "R3 random"),
                      ($urandom % 8) != 0, c, w, 16'($urandom),
                      1'($urandom), 1'($urandom));
        end

        // Reset mid-run clears the flag (R1)
        apply("R2 set before reset", 1'b1, 3'd0, 1'b0, 16'h0000, 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        model = 1'b0;
        check("R1 mid-run reset", 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule